// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Both-Edge Change Interrupts

The controller serves up to 32 general-purpose lines through a small word-addressed register port with separate read and write strobes. Software sets each line's direction, writes an output latch that drives the output pins, and reads back line levels. Input levels pass through a two-stage synchroniser before they are used.

Every transition on an input line, rising or falling, sets a sticky per-line change bit. Software clears a change bit by writing a 1 to it. A per-line enable mask gates the change bits, and the gated bits are ORed into one level interrupt for a parent interrupt controller. Two further word locations hold plain storage with no effect on the lines.

Top module: `gpio_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, all registers are zero: every line is an input, `pin_o` and `pin_oe_o` are 0, no change bit is pending, every line is masked and `irq_o` is 0.
- R2: The direction register sits at byte offset 0x00. Bit n = 1 makes line n an output (`pin_oe_o[n]` = 1), and bit n = 0 makes it an input. `pin_oe_o` changes only on a write to 0x00.
- R3: The output latch sits at offset 0x04 and drives `pin_o` on the edge that takes the write, whatever the direction. `pin_o` changes only on a write to 0x04.
- R4: A read of 0x04 returns, for each input line n, the level of `pin_i[n]` sampled two clock edges before the read edge. For each output line it returns the output latch bit.
- R5: A change of level on an input line, in either direction, sets change bit n (offset 0x0C) on the third clock edge after the new level is first sampled. A change on an output line sets nothing.
- R6: Writing 0x0C clears each change bit whose data bit is 1 and leaves each bit whose data bit is 0. Change bits hold otherwise.
- R7: If a new edge on line n sets change bit n in the same cycle as a write-1 clear of that bit, the bit stays set.
- R8: The enable register sits at offset 0x08, where 1 unmasks a line. `irq_o` is 1 exactly when some bit is set both in the change register and in the enable register. It follows the registers with no extra cycle.
- R9: Offsets 0x10 and 0x14 are read/write storage with no effect on pins or interrupt. A read of any other unmapped offset returns 0.
- R10: `rdata_o` takes the value of the addressed register on the clock edge that samples `rd_i` = 1. It shows the state from before a write taken on the same edge. It holds its value while `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | NUM_LINES | Line levels from the pads |
| pin_o | output | NUM_LINES | Output latch to the pads |
| pin_oe_o | output | NUM_LINES | Per-line output enable |
| irq_o | output | 1 | Combined change interrupt |

## Verification
On every cycle the assertions check four things. Output enables and output levels move only on writes to their own offsets. Change bits drop only on a write to the change offset. A synchronised edge on an input line is always recorded, and this includes the cycle where it collides with a clear. The interrupt rises only after a new change bit or an enable write. Several behaviours can be shown only by the bench's scenarios, run against its cycle model: the exact three-edge latency from pin to change bit, the merging of latch and pin values in the data readback, the sampling of read data before a same-edge write, and the zero value of unmapped reads.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFF_DIR   = 8'h00;
  localparam logic [7:0] OFF_DOUT  = 8'h04;
  localparam logic [7:0] OFF_IEN   = 8'h08;
  localparam logic [7:0] OFF_CHG   = 8'h0C;
  localparam logic [7:0] OFF_SPARE0 = 8'h10;
  localparam logic [7:0] OFF_SPARE1 = 8'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_DOUT,
    SEL_IEN,
    SEL_CHG,
    SEL_SPARE0,
    SEL_SPARE1,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] prev_q, chg_q, edge_w;

  // both edges, input lines only
  assign edge_w = (sync_i ^ prev_q) & ~dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      chg_q  <= '0;
    end else begin
      prev_q <= sync_i;
      chg_q  <= (chg_q & ~clr_i) | edge_w; // new edge beats clear
    end
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIDTH-1:0]  sync_i,
  input  logic [WIDTH-1:0]  chg_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  dout_o,
  output logic [WIDTH-1:0]  ien_o,
  output logic [WIDTH-1:0]  clr_o
);
  reg_sel_e sel;
  logic [WIDTH-1:0] dir_q, dout_q, ien_q, sp0_q, sp1_q, wbits, mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    if      (addr_i == ADDR_W'(OFF_DIR))    sel = SEL_DIR;
    else if (addr_i == ADDR_W'(OFF_DOUT))   sel = SEL_DOUT;
    else if (addr_i == ADDR_W'(OFF_IEN))    sel = SEL_IEN;
    else if (addr_i == ADDR_W'(OFF_CHG))    sel = SEL_CHG;
    else if (addr_i == ADDR_W'(OFF_SPARE0)) sel = SEL_SPARE0;
    else if (addr_i == ADDR_W'(OFF_SPARE1)) sel = SEL_SPARE1;
    else                                    sel = SEL_NONE;
  end

  assign wbits = wdata_i[WIDTH-1:0];
  assign clr_o = (wr_i && sel == SEL_CHG) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dout_q <= '0;
      ien_q  <= '0;
      sp0_q  <= '0;
      sp1_q  <= '0;
    end else if (wr_i) begin
      unique case (sel)
        SEL_DIR:    dir_q  <= wbits;
        SEL_DOUT:   dout_q <= wbits;
        SEL_IEN:    ien_q  <= wbits;
        SEL_SPARE0: sp0_q  <= wbits;
        SEL_SPARE1: sp1_q  <= wbits;
        default:    ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIR:    mux = dir_q;
      SEL_DOUT:   mux = (sync_i & ~dir_q) | (dout_q & dir_q);
      SEL_IEN:    mux = ien_q;
      SEL_CHG:    mux = chg_i;
      SEL_SPARE0: mux = sp0_q;
      SEL_SPARE1: mux = sp1_q;
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= DATA_W'(mux);
  end

  assign rdata_o = rdata_q;
  assign dir_o   = dir_q;
  assign dout_o  = dout_q;
  assign ien_o   = ien_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] sync_q, chg_q, dir_q, dout_q, ien_q, clr_w;

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_LEN)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_q)
  );

  gpio_edge_capture #(.WIDTH(NUM_LINES)) i_capture (
    .clk_i, .rst_ni, .sync_i(sync_q), .dir_i(dir_q), .clr_i(clr_w), .chg_o(chg_q)
  );

  gpio_regs #(.WIDTH(NUM_LINES), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .sync_i(sync_q), .chg_i(chg_q),
    .dir_o(dir_q), .dout_o(dout_q), .ien_o(ien_q), .clr_o(clr_w)
  );

  assign pin_o    = dout_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(chg_q & ien_q);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_i,
  input logic [NUM_LINES-1:0] pin_o,
  input logic [NUM_LINES-1:0] pin_oe_o,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] sync_q,
  input logic [NUM_LINES-1:0] chg_q,
  input logic [NUM_LINES-1:0] dir_q
);
  logic [NUM_LINES-1:0] seen_q, edges;
  logic wr_dir, wr_dout, wr_ien, wr_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= sync_q;
  end

  assign edges   = (sync_q ^ seen_q) & ~dir_q;
  assign wr_dir  = wr_i && addr_i == ADDR_W'(OFF_DIR);
  assign wr_dout = wr_i && addr_i == ADDR_W'(OFF_DOUT);
  assign wr_ien  = wr_i && addr_i == ADDR_W'(OFF_IEN);
  assign wr_chg  = wr_i && addr_i == ADDR_W'(OFF_CHG);

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(pin_oe_o)); // R2
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dout |=> $stable(pin_o)); // R3
  AST_EDGE_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edges) |=> ((chg_q & $past(edges)) == $past(edges))); // R5 R7
  AST_CHG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_chg |=> ((chg_q & $past(chg_q)) == $past(chg_q))); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(wr_ien) || (|(chg_q & ~$past(chg_q))))); // R8
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o),
  .sync_q(sync_q), .chg_q(chg_q), .dir_q(dir_q)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/100ps
module test_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, pin = '0;
  logic [31:0] rdata, pout, poe;
  logic        irq;
  int unsigned total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model
  logic [31:0] m_dir, m_dout, m_ien, m_chg, m_sp0, m_sp1, m_rdata;
  logic [31:0] ph[$];
  logic [7:0]  m_last_addr;
  logic        m_read_now;

  function automatic logic [31:0] m_read(logic [7:0] a, logic [31:0] lvl);
    case (a)
      8'h00: return m_dir;
      8'h04: return (lvl & ~m_dir) | (m_dout & m_dir);
      8'h08: return m_ien;
      8'h0C: return m_chg;
      8'h10: return m_sp0;
      8'h14: return m_sp1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R4";
      8'h08: return "R8";
      8'h0C: return "R5";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_dout = 0; m_ien = 0; m_chg = 0; m_sp0 = 0; m_sp1 = 0;
      m_rdata = 0; m_last_addr = 0; m_read_now = 0;
      ph = {32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] lvl, older, edg, nchg;
      lvl   = ph[1];
      older = ph[2];
      edg   = (lvl ^ older) & ~m_dir;
      m_read_now = rd;
      if (rd) begin
        m_rdata = m_read(addr, lvl);
        m_last_addr = addr;
      end
      nchg = m_chg;
      if (wr && addr == 8'h0C) nchg = nchg & ~wdata;
      nchg = nchg | edg;
      if (wr) case (addr)
        8'h00: m_dir  = wdata;
        8'h04: m_dout = wdata;
        8'h08: m_ien  = wdata;
        8'h10: m_sp0  = wdata;
        8'h14: m_sp1  = wdata;
        default: ;
      endcase
      m_chg = nchg;
      ph.push_front(pin);
      void'(ph.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", poe, m_dir);
      check("R3", pout, m_dout);
      check("R8", {31'h0, irq}, {31'h0, |(m_chg & m_ien)});
      check(m_read_now ? tag_for(m_last_addr) : "R10", rdata, m_rdata);
    end
  end

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic do_rd(logic [7:0] a);
    @(posedge clk); #1;
    rd = 1; addr = a;
    @(posedge clk); #1;
    rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1", poe, 32'h0);
    check("R1", pout, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);
    rst_n = 1;
    idle(2);
    do_rd(8'h0C);
    check("R1", rdata, 32'h0);

    // R2 R3: lower half outputs
    do_wr(8'h00, 32'h0000FFFF);
    do_wr(8'h04, 32'hA5A5A5A5);
    check("R3", pout, 32'hA5A5A5A5);
    check("R2", poe, 32'h0000FFFF);
    do_rd(8'h00);

    // R4 R5: toggle input and output lines
    pin = 32'h1234_5678;
    idle(5);
    do_rd(8'h04);
    check("R4", rdata, 32'h1234_A5A5);
    do_rd(8'h0C);
    check("R5", rdata, 32'h1234_0000);

    // R8 R6: enable, partial clear, zero write
    do_wr(8'h08, 32'h0004_0000);
    check("R8", {31'h0, irq}, 32'h1);
    do_wr(8'h0C, 32'h0000_0000);
    do_rd(8'h0C);
    check("R6", rdata, 32'h1234_0000);
    do_wr(8'h0C, 32'h0004_0000);
    check("R8", {31'h0, irq}, 32'h0);
    do_rd(8'h0C);
    check("R6", rdata, 32'h1230_0000);
    do_wr(8'h0C, 32'hFFFF_FFFF);

    // R7: edge lands on the clearing edge
    idle(5);
    pin[20] = ~pin[20];
    @(posedge clk); @(posedge clk); #1;
    wr = 1; addr = 8'h0C; wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    wr = 0;
    do_rd(8'h0C);
    check("R7", rdata, 32'h0010_0000);

    // R9: spare storage, unmapped zero
    do_wr(8'h10, 32'hDEAD_BEEF);
    do_wr(8'h14, 32'h0BAD_F00D);
    do_rd(8'h10);
    check("R9", rdata, 32'hDEAD_BEEF);
    do_rd(8'h14);
    check("R9", rdata, 32'h0BAD_F00D);
    check("R9", poe, 32'h0000FFFF);
    do_rd(8'h18);
    check("R9", rdata, 32'h0);

    // R10: read and write on the same edge
    @(posedge clk); #1;
    wr = 1; rd = 1; addr = 8'h08; wdata = 32'h0000_00F0;
    @(posedge clk); #1;
    wr = 0; rd = 0;
    check("R10", rdata, 32'h0004_0000);
    idle(3);
    check("R10", rdata, 32'h0004_0000);
    do_rd(8'h08);
    check("R10", rdata, 32'h0000_00F0);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      wr    = ($urandom_range(0, 3) == 0);
      rd    = ($urandom_range(0, 2) == 0);
      addr  = 8'($urandom_range(0, 7) * 4);
      wdata = $urandom;
      if ($urandom_range(0, 2) == 0) pin = pin ^ ($urandom & $urandom);
    end
    @(posedge clk); #1;
    wr = 0; rd = 0;
    idle(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule